// File: doc/BRIEF.md
# Special-Operand Resolver for Floating-Point Addition

This block settles the result of a floating-point add or subtract whenever at least one operand is not an ordinary normalised number. For each operand it takes a 3-bit class code, the sign that operand carries once any subtract or operand-swap inversion has been applied, and the raw exponent and significand. It also takes the rounding-mode field and a mask bit for the denormal-operand exception. From these it returns the result class, sign, exponent and significand. It also returns flags for an invalid operation, for a denormal operand seen, and for an abort. A separate select output tells the caller that the pair must go to its NaN handling instead.

The decision logic is combinational. A single output register captures a result on every cycle that `in_valid` is high, and `out_valid` follows one cycle later. The surrounding adder sends the operand pair here when its class check finds a zero, denormal, infinity or NaN. It uses the registered outputs and discards the result fields when `flag_abort` is set.

Top module: `fsr_special_resolve`

## Requirements
- R1: A result appears on the outputs one clock after `in_valid` is sampled high, with `out_valid` high for that cycle. When `in_valid` is low, `out_valid` falls on the next clock and every result output keeps its value. A synchronous active-low reset clears all outputs to zero.
- R2: Class codes are 0 zero, 1 valid, 2 denormal, 3 infinity, 4 NaN, and `res_cls` uses the same codes. If either operand has class 4, `nan_sel` is 1 and `res_cls` is 4. Sign, exponent, significand and the other three flags are all 0.
- R3: If neither operand is NaN and at least one has class 2, `flag_denorm` is 1. Otherwise it is 0.
- R4: If R3 raises `flag_denorm` while `denorm_mask` is 0 (the exception is unmasked), `flag_abort` is 1. The result is then class 0 with sign, exponent and significand all 0, and `flag_invalid` is 0.
- R5: Zero plus zero with equal effective signs gives class 0, that sign, and exponent and significand 0.
- R6: Zero plus zero with differing effective signs gives class 0 with sign 0. The exception is `rnd_mode` = 2'b01 (toward minus infinity), where the sign is 1.
- R7: Zero with a nonzero operand returns that operand's class, exponent and significand, with its effective sign as the result sign.
- R8: If the operand copied under R7 has class 2 and significand bit SIG_W-1 set, the result has class 1, and its exponent is the operand's exponent plus one (modulo 2^EXP_W).
- R9: An infinity with a finite nonzero operand, or with an infinity of the same effective sign, gives that infinite operand's class, exponent, significand and effective sign.
- R10: Two infinities of opposite effective sign set `flag_invalid` and return class 4, sign 1, exponent all ones and significand with only its two top bits set, with `nan_sel` 0.
- R11: Two finite nonzero operands (each class 1 or 2), when not aborted, give class 0 with all data 0 and `flag_invalid` 0. `flag_denorm` still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_cls | input | 3 | Class code of operand A |
| a_sign | input | 1 | Effective sign of operand A |
| a_exp | input | EXP_W | Exponent of operand A |
| a_sig | input | SIG_W | Significand of operand A |
| b_cls | input | 3 | Class code of operand B |
| b_sign | input | 1 | Effective sign of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| b_sig | input | SIG_W | Significand of operand B |
| rnd_mode | input | 2 | Rounding mode, 2'b01 = toward minus infinity |
| denorm_mask | input | 1 | 1 masks the denormal-operand exception |
| out_valid | output | 1 | Registered result valid |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_sig | output | SIG_W | Result significand |
| flag_invalid | output | 1 | Invalid operation |
| flag_denorm | output | 1 | Denormal operand seen |
| flag_abort | output | 1 | Unmasked denormal, result void |
| nan_sel | output | 1 | Route the pair to NaN handling |

## Verification
The denormal flag can be raised in the same cycle that a result is produced. One case is a masked denormal combined with zero, which is copied and may also be converted as a pseudo-denormal. Another is a masked denormal combined with an infinity. The sweep covers every pair of classes and signs, every rounding mode, both mask settings, and denormal significands with the top bit set and clear. So each such overlap occurs with the mask both set and clear. Each outcome is compared as one word holding class, sign, exponent, significand and all four flags, against a value derived from the requirements. A wrong priority, such as a missing flag beside a good result, or a result written beside an abort, therefore fails.

// File: rtl/fsr_pkg.sv
// Shared class codes and mode constants for the special-operand resolver.
// Assumes the caller encodes operand classes with exactly these codes.
package fsr_pkg;
    localparam logic [2:0] CLS_ZERO   = 3'd0;
    localparam logic [2:0] CLS_VALID  = 3'd1;
    localparam logic [2:0] CLS_DENORM = 3'd2;
    localparam logic [2:0] CLS_INF    = 3'd3;
    localparam logic [2:0] CLS_NAN    = 3'd4;
    localparam logic [1:0] RND_DOWN   = 2'b01;
endpackage

// File: rtl/fsr_operand_norm.sv
// Converts a pseudo-denormal operand (denormal class with the significand's
// top bit set) to a valid one by bumping its exponent. Other operands pass
// through unchanged. Assumes the exponent may wrap on overflow.
module fsr_operand_norm
    import fsr_pkg::*;
#(
    parameter int EXP_W = 15
) (
    input  logic [2:0]       cls_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             sig_msb_i,
    output logic [2:0]       cls_o,
    output logic [EXP_W-1:0] exp_o
);
    // Reclassify and adjust exponent of a pseudo-denormal.
    always_comb begin
        cls_o = cls_i;
        exp_o = exp_i;
        if (cls_i == CLS_DENORM && sig_msb_i) begin
            cls_o = CLS_VALID;
            exp_o = exp_i + EXP_W'(1);
        end
    end
endmodule

// File: rtl/fsr_zero_path.sv
// Resolves any pair where at least one operand is zero. Zero plus zero takes a
// sign from the operand signs or the rounding mode. Otherwise the nonzero
// operand is copied with its effective sign. Assumes NaN pairs are filtered
// upstream and operands are already pseudo-denormal normalised.
module fsr_zero_path
    import fsr_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [2:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic [2:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic [1:0]       rnd_mode,
    output logic             hit,
    output logic [2:0]       z_cls,
    output logic             z_sign,
    output logic [EXP_W-1:0] z_exp,
    output logic [SIG_W-1:0] z_sig
);
    logic a_zero, b_zero;
    assign a_zero = (a_cls == CLS_ZERO);
    assign b_zero = (b_cls == CLS_ZERO);

    // Select the zero-pair result or copy the nonzero operand.
    always_comb begin
        hit    = 1'b1;
        z_cls  = CLS_ZERO;
        z_sign = 1'b0;
        z_exp  = '0;
        z_sig  = '0;
        if (a_zero && b_zero) begin
            z_sign = (a_sign == b_sign) ? a_sign : (rnd_mode == RND_DOWN);
        end else if (a_zero) begin
            z_cls  = b_cls;
            z_sign = b_sign;
            z_exp  = b_exp;
            z_sig  = b_sig;
        end else if (b_zero) begin
            z_cls  = a_cls;
            z_sign = a_sign;
            z_exp  = a_exp;
            z_sig  = a_sig;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fsr_inf_path.sv
// Resolves pairs with at least one infinity and no zero. It picks which
// infinite operand to return, or reports an invalid operation for opposite
// infinities. Assumes zero and NaN pairs are handled by higher priority logic.
module fsr_inf_path
    import fsr_pkg::*;
(
    input  logic [2:0] a_cls,
    input  logic       a_sign,
    input  logic [2:0] b_cls,
    input  logic       b_sign,
    output logic       hit,
    output logic       invalid,
    output logic       pick_b
);
    logic a_inf, b_inf;
    assign a_inf = (a_cls == CLS_INF);
    assign b_inf = (b_cls == CLS_INF);

    // Decide the infinite result source or flag infinity minus infinity.
    always_comb begin
        hit     = a_inf || b_inf;
        invalid = a_inf && b_inf && (a_sign != b_sign);
        pick_b  = !a_inf && b_inf;
    end
endmodule

// File: rtl/fsr_special_resolve.sv
// Top of the special-operand resolver. Gives NaN routing priority, then the
// denormal abort, then zero handling, then infinity handling. The result is
// registered with a one-cycle valid. Assumes effective signs already include
// any subtract or reverse inversion.
module fsr_special_resolve
    import fsr_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       a_cls,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic [2:0]       b_cls,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic [1:0]       rnd_mode,
    input  logic             denorm_mask,
    output logic             out_valid,
    output logic [2:0]       res_cls,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [SIG_W-1:0] res_sig,
    output logic             flag_invalid,
    output logic             flag_denorm,
    output logic             flag_abort,
    output logic             nan_sel
);
    localparam int NOPS = 2;
    localparam logic [SIG_W-1:0] INDEF_SIG = {2'b11, {(SIG_W-2){1'b0}}};
    localparam logic [EXP_W-1:0] EXP_ONES  = '1;

    logic [2:0]       in_cls  [NOPS];
    logic [EXP_W-1:0] in_exp  [NOPS];
    logic             in_msb  [NOPS];
    logic [2:0]       nrm_cls [NOPS];
    logic [EXP_W-1:0] nrm_exp [NOPS];

    assign in_cls[0] = a_cls;
    assign in_cls[1] = b_cls;
    assign in_exp[0] = a_exp;
    assign in_exp[1] = b_exp;
    assign in_msb[0] = a_sig[SIG_W-1];
    assign in_msb[1] = b_sig[SIG_W-1];

    for (genvar i = 0; i < NOPS; i++) begin : g_norm
        fsr_operand_norm #(.EXP_W(EXP_W)) u_norm (
            .cls_i     (in_cls[i]),
            .exp_i     (in_exp[i]),
            .sig_msb_i (in_msb[i]),
            .cls_o     (nrm_cls[i]),
            .exp_o     (nrm_exp[i])
        );
    end

    logic             z_hit;
    logic [2:0]       z_cls;
    logic             z_sign;
    logic [EXP_W-1:0] z_exp;
    logic [SIG_W-1:0] z_sig;

    fsr_zero_path #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_zero (
        .a_cls    (nrm_cls[0]),
        .a_sign   (a_sign),
        .a_exp    (nrm_exp[0]),
        .a_sig    (a_sig),
        .b_cls    (nrm_cls[1]),
        .b_sign   (b_sign),
        .b_exp    (nrm_exp[1]),
        .b_sig    (b_sig),
        .rnd_mode (rnd_mode),
        .hit      (z_hit),
        .z_cls    (z_cls),
        .z_sign   (z_sign),
        .z_exp    (z_exp),
        .z_sig    (z_sig)
    );

    logic i_hit, i_invalid, i_pick_b;

    fsr_inf_path u_inf (
        .a_cls   (a_cls),
        .a_sign  (a_sign),
        .b_cls   (b_cls),
        .b_sign  (b_sign),
        .hit     (i_hit),
        .invalid (i_invalid),
        .pick_b  (i_pick_b)
    );

    logic             is_nan, is_den, do_abort;
    logic [2:0]       n_cls;
    logic             n_sign, n_inv;
    logic [EXP_W-1:0] n_exp;
    logic [SIG_W-1:0] n_sig;

    assign is_nan   = (a_cls == CLS_NAN) || (b_cls == CLS_NAN);
    assign is_den   = !is_nan && ((a_cls == CLS_DENORM) || (b_cls == CLS_DENORM));
    assign do_abort = is_den && !denorm_mask;

    // Priority select among NaN route, abort, zero path and infinity path.
    always_comb begin
        n_cls  = CLS_ZERO;
        n_sign = 1'b0;
        n_exp  = '0;
        n_sig  = '0;
        n_inv  = 1'b0;
        if (is_nan) begin
            n_cls = CLS_NAN;
        end else if (do_abort) begin
            n_cls = CLS_ZERO;
        end else if (z_hit) begin
            n_cls  = z_cls;
            n_sign = z_sign;
            n_exp  = z_exp;
            n_sig  = z_sig;
        end else if (i_invalid) begin
            n_inv  = 1'b1;
            n_cls  = CLS_NAN;
            n_sign = 1'b1;
            n_exp  = EXP_ONES;
            n_sig  = INDEF_SIG;
        end else if (i_hit) begin
            n_cls  = CLS_INF;
            n_sign = i_pick_b ? b_sign : a_sign;
            n_exp  = i_pick_b ? b_exp  : a_exp;
            n_sig  = i_pick_b ? b_sig  : a_sig;
        end
    end

    // Output register: capture on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            res_cls      <= CLS_ZERO;
            res_sign     <= 1'b0;
            res_exp      <= '0;
            res_sig      <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
            flag_abort   <= 1'b0;
            nan_sel      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_cls      <= n_cls;
                res_sign     <= n_sign;
                res_exp      <= n_exp;
                res_sig      <= n_sig;
                flag_invalid <= n_inv;
                flag_denorm  <= is_den;
                flag_abort   <= do_abort;
                nan_sel      <= is_nan;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_sig) && $stable(res_cls)));
    // R2
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nan_sel |-> (!flag_denorm && !flag_invalid && !flag_abort && res_cls == CLS_NAN));
    // R4
    abort_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_abort |-> (flag_denorm && !flag_invalid && res_sig == '0 && res_exp == '0));
    // R10
    indef_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (res_sign && res_exp == EXP_ONES && res_sig == INDEF_SIG && !nan_sel));
endmodule

// File: tb/sim_fsr_special_resolve.sv
module sim_fsr_special_resolve;
    localparam int EW = 15;
    localparam int SW = 64;
    localparam logic [2:0] C_ZERO = 3'd0, C_VAL = 3'd1, C_DEN = 3'd2, C_INF = 3'd3, C_NAN = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [SW-1:0] a_sig = '0, b_sig = '0;
    logic [1:0] rnd_mode = '0;
    logic denorm_mask = 1'b0;
    logic out_valid, res_sign, flag_invalid, flag_denorm, flag_abort, nan_sel;
    logic [2:0] res_cls;
    logic [EW-1:0] res_exp;
    logic [SW-1:0] res_sig;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    fsr_special_resolve #(.EXP_W(EW), .SIG_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .rnd_mode(rnd_mode), .denorm_mask(denorm_mask),
        .out_valid(out_valid), .res_cls(res_cls), .res_sign(res_sign),
        .res_exp(res_exp), .res_sig(res_sig), .flag_invalid(flag_invalid),
        .flag_denorm(flag_denorm), .flag_abort(flag_abort), .nan_sel(nan_sel)
    );

    function automatic logic [86:0] pack_out(logic [2:0] c, logic s, logic [EW-1:0] e,
                                             logic [SW-1:0] g, logic iv, logic dn,
                                             logic ab, logic ns);
        return {c, s, e, g, iv, dn, ab, ns};
    endfunction

    task automatic check(string tag, logic [86:0] act, logic [86:0] exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Operand values per class; idx separates A from B, pv sets denormal top bit.
    task automatic mk_op(logic [2:0] c, int idx, int pv,
                         output logic [EW-1:0] e, output logic [SW-1:0] g);
        case (c)
            C_ZERO: begin e = '0; g = '0; end
            C_VAL:  begin e = EW'(16'h3FF0 + idx); g = 64'h8000_0000_0000_0010 + SW'(idx); end
            C_DEN:  begin e = EW'(idx); g = (pv != 0 ? 64'h8000_0000_0000_0ABC : 64'h0000_0000_0000_0ABC) + SW'(idx); end
            C_INF:  begin e = '1; g = 64'h8000_0000_0000_0000; end
            default: begin e = '1; g = 64'hC000_0000_0000_0001; end
        endcase
    endtask

    // Expected outcome, derived from the requirement list.
    task automatic model(output logic [86:0] r, output string tag);
        logic den;
        logic [2:0] cc;
        logic [EW-1:0] ee;
        den = 1'b0;
        if (a_cls == C_NAN || b_cls == C_NAN) begin
            r = pack_out(C_NAN, 0, '0, '0, 0, 0, 0, 1); tag = "R2";
            return;
        end
        den = (a_cls == C_DEN) || (b_cls == C_DEN);
        if (den && !denorm_mask) begin
            r = pack_out(C_ZERO, 0, '0, '0, 0, 1, 1, 0); tag = "R4";
            return;
        end
        if (a_cls == C_ZERO && b_cls == C_ZERO) begin
            if (a_sign == b_sign) begin
                r = pack_out(C_ZERO, a_sign, '0, '0, 0, den, 0, 0); tag = "R5";
            end else begin
                r = pack_out(C_ZERO, rnd_mode == 2'b01, '0, '0, 0, den, 0, 0); tag = "R6";
            end
        end else if (a_cls == C_ZERO || b_cls == C_ZERO) begin
            cc = (a_cls == C_ZERO) ? b_cls : a_cls;
            ee = (a_cls == C_ZERO) ? b_exp : a_exp;
            tag = "R7";
            if (cc == C_DEN && ((a_cls == C_ZERO) ? b_sig[SW-1] : a_sig[SW-1])) begin
                cc = C_VAL; ee = ee + 1'b1; tag = "R8";
            end
            r = pack_out(cc, (a_cls == C_ZERO) ? b_sign : a_sign, ee,
                         (a_cls == C_ZERO) ? b_sig : a_sig, 0, den, 0, 0);
        end else if (a_cls == C_INF && b_cls == C_INF && a_sign != b_sign) begin
            r = pack_out(C_NAN, 1, '1, 64'hC000_0000_0000_0000, 1, 0, 0, 0); tag = "R10";
        end else if (a_cls == C_INF) begin
            r = pack_out(C_INF, a_sign, a_exp, a_sig, 0, den, 0, 0); tag = "R9";
        end else if (b_cls == C_INF) begin
            r = pack_out(C_INF, b_sign, b_exp, b_sig, 0, den, 0, 0); tag = "R9";
        end else begin
            r = pack_out(C_ZERO, 0, '0, '0, 0, den, 0, 0); tag = "R11";
        end
        if (den && tag != "R4") tag = {tag, "+R3"};
    endtask

    function automatic logic [86:0] cur_out();
        return pack_out(res_cls, res_sign, res_exp, res_sig, flag_invalid, flag_denorm, flag_abort, nan_sel);
    endfunction

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [86:0] expv, held;
        string tag;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {out_valid, cur_out()}, 88'd0);
        rst_n = 1'b1;
        for (int ca = 0; ca < 5; ca++)
        for (int cb = 0; cb < 5; cb++)
        for (int s = 0; s < 4; s++)
        for (int rm = 0; rm < 4; rm++)
        for (int mk = 0; mk < 2; mk++)
        for (int pv = 0; pv < 2; pv++) begin
            @(negedge clk);
            a_cls = 3'(ca); b_cls = 3'(cb);
            a_sign = s[0]; b_sign = s[1];
            mk_op(a_cls, 1, pv, a_exp, a_sig);
            mk_op(b_cls, 2, pv, b_exp, b_sig);
            rnd_mode = 2'(rm); denorm_mask = mk[0];
            in_valid = 1'b1;
            model(expv, tag);
            @(negedge clk);
            check({tag, " valid"}, {87'd0, out_valid}, 87'd1);
            check(tag, cur_out(), expv);
            // R1: idle cycle holds the result and drops valid
            if (pv == 1 && mk == 1) begin
                held = cur_out();
                in_valid = 1'b0;
                a_cls = C_INF; b_cls = C_INF; a_sign = 1'b0; b_sign = 1'b1;
                @(negedge clk);
                check("R1 hold", {out_valid, cur_out()}, {1'b0, held});
            end
        end
        // R8: exponent wrap on pseudo-denormal at the top exponent
        @(negedge clk);
        a_cls = C_ZERO; a_exp = '0; a_sig = '0; a_sign = 1'b1;
        b_cls = C_DEN; b_exp = '1; b_sig = 64'h8000_0000_0000_0001; b_sign = 1'b1;
        denorm_mask = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R8 wrap", cur_out(), pack_out(C_VAL, 1, '0, 64'h8000_0000_0000_0001, 0, 1, 0, 0));
        in_valid = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule